// File: doc/BRIEF.md
# Byte-Code Command Sequencer

The sequencer runs short programs of one-byte opcodes that a host places in a shared byte-wide SRAM. A start strobe carries the address of the first opcode. From there the engine fetches opcodes one at a time, reads any operand bytes that follow each opcode, and acts on them until it reaches an END opcode. The commands drive a separate statistics accumulator. They clear it, start it and stop it, load its 16-bit channel-enable mask and reload its sample timer. Two commands write data back into the same SRAM: one dumps the accumulator's record bytes and one writes a fixed-format information block. Each takes its destination address as an operand.

While a program runs, busy is high. When the program ends, done pulses for one cycle. If the program contained an undefined opcode, ran off the end of the address space, used an unsupported timer prescale or asked for a copy that would overflow the SRAM, err is raised and stays up until the next start. The accumulator reads its sensors on its own, and that part is not in this block. It only offers its record bytes through a byte-index port.

Top module: `opseq_engine`

## Requirements
- R1: After reset, busy, done and err are 0, no strobe is active, chan_mask is 0x0000 and tmr_reload is 0x00.
- R2: A go pulse while idle starts execution at go_addr. busy stays high until END (0x00) is executed, and then done is high for exactly one cycle with busy low. A go pulse while busy is ignored.
- R3: Opcodes 0x10, 0x11 and 0x12 each produce a one-cycle pulse on acc_clear, acc_start and acc_stop respectively. The pulses come in program order, and no two strobes are ever high in the same cycle.
- R4: Opcode 0x14 reads two operand bytes, high byte first, then loads them into chan_mask with a one-cycle mask_ld pulse.
- R5: Opcode 0x15 reads four operand bytes: prescale, reload and two ignored bytes. With prescale 0, tmr_reload takes the reload byte and tmr_ld pulses. With any other prescale, err is raised, tmr_reload keeps its value and execution stops.
- R6: Opcode 0x13 reads a destination byte D and writes record byte k (fetched with rec_idx = k) to address D+k, for k from 0 to NREC*REC_BYTES-1. D becomes the stored record address.
- R7: Opcode 0x31 reads a destination D and writes 10 bytes from D onward in this order: version high, version low, prescale (0), tmr_reload, NREC, 0x00, stored record address (reset value 0x80), then three 0x00 bytes.
- R8: A copy whose last byte would fall above 0xFE raises err, writes nothing and stops execution.
- R9: An opcode outside the eight defined values raises err and stops execution, and no strobe follows it.
- R10: A fetch of an opcode or operand at address 0xFF raises err and stops execution.
- R11: err is raised in the same cycle as done, stays high while idle, and is cleared by the next accepted go.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go | input | 1 | Start strobe |
| go_addr | input | 8 | Address of the first opcode |
| mem_rd | output | 1 | SRAM read enable (data valid the next cycle) |
| mem_we | output | 1 | SRAM write enable |
| mem_addr | output | 8 | SRAM address |
| mem_wdata | output | 8 | SRAM write data |
| mem_rdata | input | 8 | SRAM read data |
| rec_idx | output | IDX_W | Byte index into the accumulator records |
| rec_data | input | 8 | Record byte selected by rec_idx |
| busy | output | 1 | Program running |
| done | output | 1 | One-cycle end-of-program pulse |
| err | output | 1 | Program ended with an error |
| acc_clear | output | 1 | Clear-accumulator strobe |
| acc_start | output | 1 | Start-collection strobe |
| acc_stop | output | 1 | Stop-collection strobe |
| mask_ld | output | 1 | chan_mask load strobe |
| chan_mask | output | 16 | Channel-enable mask |
| tmr_ld | output | 1 | tmr_reload load strobe |
| tmr_reload | output | 8 | Sample-timer reload value |

## Verification
The hardest case to reach is running off the top of the address space. The stimulus places a program without END at 0xFC, so the engine executes three clear commands and then has to refuse the fetch at 0xFF. The order of strobes, and their absence after a faulting opcode or a bad prescale, is checked against a log the bench records at each clock edge. A second go is pulsed in the middle of a long record dump, and the bench confirms that the program it points to never runs.

// File: rtl/opseq_pkg.sv
package opseq_pkg;

  localparam logic [7:0] OP_END    = 8'h00;
  localparam logic [7:0] OP_SCLR   = 8'h10;
  localparam logic [7:0] OP_START  = 8'h11;
  localparam logic [7:0] OP_STOP   = 8'h12;
  localparam logic [7:0] OP_GET    = 8'h13;
  localparam logic [7:0] OP_ENABLE = 8'h14;
  localparam logic [7:0] OP_TIMER  = 8'h15;
  localparam logic [7:0] OP_INFO   = 8'h31;

  localparam int unsigned INFO_LEN = 10;
  localparam logic [7:0]  LAST_ADDR = 8'hFF;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_OPC, ST_ARG_RD, ST_ARG, ST_EXEC, ST_COPY, ST_FIN
  } state_e;

  function automatic logic op_known(input logic [7:0] op);
    case (op)
      OP_END, OP_SCLR, OP_START, OP_STOP, OP_GET,
      OP_ENABLE, OP_TIMER, OP_INFO: return 1'b1;
      default:                      return 1'b0;
    endcase
  endfunction

  function automatic logic [2:0] op_args(input logic [7:0] op);
    case (op)
      OP_ENABLE:      return 3'd2;
      OP_TIMER:       return 3'd4;
      OP_GET, OP_INFO: return 3'd1;
      default:        return 3'd0;
    endcase
  endfunction

  // last written byte dst+len-1 must not exceed 0xFE
  function automatic logic copy_fits(input logic [7:0] dst, input int unsigned len);
    return (32'(dst) + len) <= 32'd255;
  endfunction

  function automatic logic [7:0] info_byte(input logic [7:0] idx, input logic [15:0] ver,
                                           input logic [7:0] rld, input logic [7:0] cnt,
                                           input logic [7:0] raddr);
    case (idx)
      8'd0:    return ver[15:8];
      8'd1:    return ver[7:0];
      8'd2:    return 8'h00;
      8'd3:    return rld;
      8'd4:    return cnt;
      8'd5:    return 8'h00;
      8'd6:    return raddr;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/opseq_args.sv
module opseq_args #(
  parameter int unsigned MAX_ARGS = 4,
  localparam int unsigned CNT_W = $clog2(MAX_ARGS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     cap,
  input  logic [7:0]               din,
  output logic [MAX_ARGS-1:0][7:0] args,
  output logic [CNT_W-1:0]         cnt
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (clr) cnt <= '0;
    else if (cap) cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < MAX_ARGS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        args[g] <= '0;
      else if (cap && cnt == CNT_W'(g))  args[g] <= din;
    end
  end

  // R5
  arg_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |-> (32'(cnt) < MAX_ARGS));

endmodule

// File: rtl/opseq_copier.sv
module opseq_copier
  import opseq_pkg::*;
#(
  parameter int unsigned GET_LEN = 99,
  parameter int unsigned NREC    = 9,
  parameter logic [15:0] VERSION = 16'h0102,
  localparam int unsigned IDX_W  = $clog2(GET_LEN),
  localparam int unsigned MAXLEN = (GET_LEN > INFO_LEN) ? GET_LEN : INFO_LEN,
  localparam int unsigned CW     = $clog2(MAXLEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic             sel_info,
  input  logic [7:0]       dst,
  input  logic [7:0]       reload,
  input  logic [7:0]       rec_addr,
  input  logic [7:0]       rec_data,
  output logic             active,
  output logic             last,
  output logic             wr,
  output logic [7:0]       waddr,
  output logic [7:0]       wdata,
  output logic [IDX_W-1:0] rec_idx
);

  logic [CW-1:0] idx;
  logic [7:0]    base;
  logic          info_q;
  logic [CW-1:0] len_m1;

  assign len_m1 = info_q ? CW'(INFO_LEN - 1) : CW'(GET_LEN - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      idx    <= '0;
      base   <= '0;
      info_q <= 1'b0;
    end else if (launch) begin
      active <= 1'b1;
      idx    <= '0;
      base   <= dst;
      info_q <= sel_info;
    end else if (active) begin
      idx <= idx + 1'b1;
      if (last) active <= 1'b0;
    end
  end

  assign last    = active && (idx == len_m1);
  assign wr      = active;
  assign waddr   = base + 8'(idx);
  assign rec_idx = IDX_W'(idx);
  assign wdata   = info_q ? info_byte(8'(idx), VERSION, reload, 8'(NREC), rec_addr)
                          : rec_data;

  // R6
  copy_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && $past(wr)) |-> (waddr == $past(waddr) + 8'd1));

endmodule

// File: rtl/opseq_engine.sv
module opseq_engine
  import opseq_pkg::*;
#(
  parameter int unsigned NREC         = 9,
  parameter int unsigned REC_BYTES    = 11,
  parameter logic [15:0] VERSION      = 16'h0102,
  parameter logic [7:0]  REC_ADDR_RST = 8'h80,
  localparam int unsigned GET_LEN     = NREC * REC_BYTES,
  localparam int unsigned IDX_W       = $clog2(GET_LEN)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [7:0]       go_addr,
  output logic             mem_rd,
  output logic             mem_we,
  output logic [7:0]       mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic [7:0]       mem_rdata,
  output logic [IDX_W-1:0] rec_idx,
  input  logic [7:0]       rec_data,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             acc_clear,
  output logic             acc_start,
  output logic             acc_stop,
  output logic             mask_ld,
  output logic [15:0]      chan_mask,
  output logic             tmr_ld,
  output logic [7:0]       tmr_reload
);

  state_e        state;
  logic [7:0]    pc;
  logic [7:0]    op_q;
  logic [2:0]    need;
  logic [7:0]    rec_addr;
  logic [3:0][7:0] args;
  logic [2:0]    arg_cnt;

  // named internal events
  logic in_exec, at_top, fetch_bad, op_bad, pre_bad, get_ok, info_ok;
  logic copy_launch, copy_active, copy_last, copy_wr;
  logic [7:0] copy_addr;

  assign in_exec   = (state == ST_EXEC);
  assign at_top    = (pc == LAST_ADDR);
  assign fetch_bad = (state == ST_FETCH || state == ST_ARG_RD) && at_top;
  assign op_bad    = (state == ST_OPC) && !op_known(mem_rdata);
  assign pre_bad   = in_exec && (op_q == OP_TIMER) && (args[0] != 8'h00);
  assign get_ok    = copy_fits(args[0], GET_LEN);
  assign info_ok   = copy_fits(args[0], INFO_LEN);
  assign copy_launch = in_exec && ((op_q == OP_GET && get_ok) || (op_q == OP_INFO && info_ok));

  opseq_args #(.MAX_ARGS(4)) u_args (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state == ST_OPC),
    .cap  (state == ST_ARG),
    .din  (mem_rdata),
    .args (args),
    .cnt  (arg_cnt)
  );

  opseq_copier #(.GET_LEN(GET_LEN), .NREC(NREC), .VERSION(VERSION)) u_copy (
    .clk     (clk),
    .rst_n   (rst_n),
    .launch  (copy_launch),
    .sel_info(op_q == OP_INFO),
    .dst     (args[0]),
    .reload  (tmr_reload),
    .rec_addr(rec_addr),
    .rec_data(rec_data),
    .active  (copy_active),
    .last    (copy_last),
    .wr      (copy_wr),
    .waddr   (copy_addr),
    .wdata   (mem_wdata),
    .rec_idx (rec_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      pc         <= '0;
      op_q       <= '0;
      need       <= '0;
      err        <= 1'b0;
      chan_mask  <= '0;
      tmr_reload <= '0;
      rec_addr   <= REC_ADDR_RST;
    end else begin
      case (state)
        ST_IDLE: if (go) begin
          pc    <= go_addr;
          err   <= 1'b0;
          state <= ST_FETCH;
        end
        ST_FETCH, ST_ARG_RD: begin
          if (at_top) begin
            err   <= 1'b1;
            state <= ST_FIN;
          end else begin
            pc    <= pc + 8'd1;
            state <= (state == ST_FETCH) ? ST_OPC : ST_ARG;
          end
        end
        ST_OPC: begin
          op_q <= mem_rdata;
          need <= op_args(mem_rdata);
          if (op_bad) begin
            err   <= 1'b1;
            state <= ST_FIN;
          end else if (op_args(mem_rdata) == 3'd0) state <= ST_EXEC;
          else                                     state <= ST_ARG_RD;
        end
        ST_ARG: state <= (arg_cnt + 3'd1 == need) ? ST_EXEC : ST_ARG_RD;
        ST_EXEC: begin
          state <= ST_FETCH;
          case (op_q)
            OP_END: state <= ST_FIN;
            OP_ENABLE: chan_mask <= {args[0], args[1]};
            OP_TIMER: begin
              if (pre_bad) begin
                err   <= 1'b1;
                state <= ST_FIN;
              end else tmr_reload <= args[1];
            end
            OP_GET: begin
              if (get_ok) begin
                rec_addr <= args[0];
                state    <= ST_COPY;
              end else begin
                err   <= 1'b1;
                state <= ST_FIN;
              end
            end
            OP_INFO: begin
              if (info_ok) state <= ST_COPY;
              else begin
                err   <= 1'b1;
                state <= ST_FIN;
              end
            end
            default: ;
          endcase
        end
        ST_COPY: if (copy_last) state <= ST_FETCH;
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE) && (state != ST_FIN);
  assign done      = (state == ST_FIN);
  assign mem_rd    = (state == ST_FETCH || state == ST_ARG_RD) && !at_top;
  assign mem_we    = copy_wr;
  assign mem_addr  = copy_active ? copy_addr : pc;
  assign acc_clear = in_exec && (op_q == OP_SCLR);
  assign acc_start = in_exec && (op_q == OP_START);
  assign acc_stop  = in_exec && (op_q == OP_STOP);
  assign mask_ld   = in_exec && (op_q == OP_ENABLE);
  assign tmr_ld    = in_exec && (op_q == OP_TIMER) && !pre_bad;

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R2
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R3
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({acc_clear, acc_start, acc_stop, mask_ld, tmr_ld}));
  // R8
  copy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr != LAST_ADDR));
  // R10
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_rd));
  // R11
  err_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> done);
  // R5
  reload_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tmr_ld |=> $stable(tmr_reload));

endmodule

// File: tb/test_opseq_engine.sv
module test_opseq_engine;

  localparam int unsigned NREC = 9, REC_BYTES = 11, GET_LEN = NREC * REC_BYTES;
  localparam int unsigned IDX_W = $clog2(GET_LEN);

  logic clk = 0, rst_n = 0, go = 0;
  logic [7:0] go_addr = 0;
  logic mem_rd, mem_we, busy, done, err;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic [IDX_W-1:0] rec_idx;
  logic [7:0] rec_data;
  logic acc_clear, acc_start, acc_stop, mask_ld, tmr_ld;
  logic [15:0] chan_mask;
  logic [7:0] tmr_reload;

  int checks = 0, errors = 0;
  logic [7:0] mem [0:255];
  int log_q [0:63];
  int nlog = 0, nmask = 0, ntmr = 0, ndone = 0;

  always #10 clk = ~clk;

  opseq_engine i_opseq_engine (
    .clk(clk), .rst_n(rst_n), .go(go), .go_addr(go_addr),
    .mem_rd(mem_rd), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rec_idx(rec_idx), .rec_data(rec_data),
    .busy(busy), .done(done), .err(err),
    .acc_clear(acc_clear), .acc_start(acc_start), .acc_stop(acc_stop),
    .mask_ld(mask_ld), .chan_mask(chan_mask), .tmr_ld(tmr_ld), .tmr_reload(tmr_reload)
  );

  function automatic logic [7:0] rec_val(input int k);
    return 8'(k * 7 + 3);
  endfunction
  assign rec_data = rec_val(int'(rec_idx));

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (acc_clear) begin log_q[nlog] = 1; nlog++; end
    if (acc_start) begin log_q[nlog] = 2; nlog++; end
    if (acc_stop)  begin log_q[nlog] = 3; nlog++; end
    if (mask_ld) nmask++;
    if (tmr_ld)  ntmr++;
    if (done)    ndone++;
  end

  task automatic check(input bit ok, input string msg, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", msg, act, exp);
    end
  endtask

  task automatic clear_logs();
    nlog = 0; nmask = 0; ntmr = 0; ndone = 0;
  endtask

  task automatic run(input logic [7:0] a);
    int t;
    clear_logs();
    @(negedge clk); go = 1; go_addr = a;
    @(negedge clk); go = 0;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    check(t < 3000, "R2 program reached done", 32'(t), 0);
    check(!busy, "R2 busy low with done", 32'(busy), 0);
    @(negedge clk);
    check(!done, "R2 done lasts one cycle", 32'(done), 0);
  endtask

  task automatic t_reset();
    check(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
    check(chan_mask == 16'h0, "R1 mask reset", chan_mask, 0);
    check(tmr_reload == 8'h0, "R1 reload reset", tmr_reload, 0);
    check(!(acc_clear | acc_start | acc_stop | mask_ld | tmr_ld), "R1 strobes low", 0, 0);
  endtask

  task automatic t_acc_order();
    mem[0] = 8'h12; mem[1] = 8'h10; mem[2] = 8'h11; mem[3] = 8'h00;
    run(8'h00);
    check(nlog == 3, "R3 strobe count", nlog, 3);
    check(log_q[0] == 3 && log_q[1] == 1 && log_q[2] == 2, "R3 stop clear start order",
          {log_q[0][7:0], log_q[1][7:0], log_q[2][7:0]}, 32'h030102);
    check(!err, "R2 clean program no err", err, 0);
  endtask

  task automatic t_enable();
    mem[8'h10] = 8'h14; mem[8'h11] = 8'hA5; mem[8'h12] = 8'h3C; mem[8'h13] = 8'h00;
    run(8'h10);
    check(chan_mask == 16'hA53C, "R4 mask high byte first", chan_mask, 16'hA53C);
    check(nmask == 1, "R4 one mask_ld", nmask, 1);
  endtask

  task automatic t_timer();
    mem[8'h20] = 8'h15; mem[8'h21] = 8'h00; mem[8'h22] = 8'h2A;
    mem[8'h23] = 8'h99; mem[8'h24] = 8'h98; mem[8'h25] = 8'h00;
    run(8'h20);
    check(tmr_reload == 8'h2A && ntmr == 1, "R5 reload loaded", tmr_reload, 8'h2A);
    mem[8'h20] = 8'h15; mem[8'h21] = 8'h03; mem[8'h22] = 8'h77;
    mem[8'h23] = 8'h00; mem[8'h24] = 8'h00; mem[8'h25] = 8'h11; mem[8'h26] = 8'h00;
    run(8'h20);
    check(err == 1'b1, "R5 nonzero prescale err", err, 1);
    check(tmr_reload == 8'h2A && ntmr == 0, "R5 reload kept", tmr_reload, 8'h2A);
    check(nlog == 0, "R5 execution stopped", nlog, 0);
    @(negedge clk);
    check(err == 1'b1, "R11 err held while idle", err, 1);
  endtask

  task automatic t_get();
    int bad = 0;
    mem[8'h00] = 8'h13; mem[8'h01] = 8'h40; mem[8'h02] = 8'h00;
    run(8'h00);
    check(!err, "R11 err cleared by go", err, 0);
    for (int k = 0; k < GET_LEN; k++)
      if (mem[8'h40 + k] !== rec_val(k)) bad++;
    check(bad == 0, "R6 record bytes copied", bad, 0);
    check(mem[8'h40 + GET_LEN - 1] == rec_val(GET_LEN - 1), "R6 last record byte",
          mem[8'h40 + GET_LEN - 1], rec_val(GET_LEN - 1));
  endtask

  task automatic t_info();
    logic [7:0] exp [0:9] = '{8'h01, 8'h02, 8'h00, 8'h2A, 8'h09, 8'h00, 8'h40, 8'h00, 8'h00, 8'h00};
    int bad = 0;
    for (int k = 0; k < 11; k++) mem[8'hB0 + k] = 8'hEE;
    mem[8'h00] = 8'h31; mem[8'h01] = 8'hB0; mem[8'h02] = 8'h00;
    run(8'h00);
    for (int k = 0; k < 10; k++)
      if (mem[8'hB0 + k] !== exp[k]) begin
        bad++;
        $display("FAIL R7 info byte %0d act=%0h exp=%0h", k, mem[8'hB0 + k], exp[k]);
      end
    check(bad == 0, "R7 info block", bad, 0);
    check(mem[8'hBA] == 8'hEE, "R7 info length 10", mem[8'hBA], 8'hEE);
  endtask

  task automatic t_bounds();
    for (int k = 8'hA0; k < 256; k++) mem[k] = 8'h5A;
    mem[8'h00] = 8'h13; mem[8'h01] = 8'hA0; mem[8'h02] = 8'h00;
    run(8'h00);
    check(err == 1'b1, "R8 oversized dump err", err, 1);
    check(mem[8'hA0] == 8'h5A && mem[8'hFE] == 8'h5A, "R8 nothing written", mem[8'hA0], 8'h5A);
    mem[8'h00] = 8'h31; mem[8'h01] = 8'hF6;
    run(8'h00);
    check(err == 1'b1 && mem[8'hF6] == 8'h5A, "R8 info overflow err", {err, mem[8'hF6]}, 9'h15A);
  endtask

  task automatic t_badop();
    mem[8'h30] = 8'h10; mem[8'h31] = 8'h77; mem[8'h32] = 8'h11; mem[8'h33] = 8'h00;
    run(8'h30);
    check(err == 1'b1, "R9 unknown opcode err", err, 1);
    check(nlog == 1 && log_q[0] == 1, "R9 no strobe after bad opcode", nlog, 1);
  endtask

  task automatic t_edge();
    mem[8'hFC] = 8'h10; mem[8'hFD] = 8'h10; mem[8'hFE] = 8'h10; mem[8'hFF] = 8'h00;
    run(8'hFC);
    check(err == 1'b1, "R10 fetch at 0xFF err", err, 1);
    check(nlog == 3, "R10 three clears before fault", nlog, 3);
    mem[8'hFD] = 8'h14; mem[8'hFE] = 8'h12;
    run(8'hFD);
    check(err == 1'b1 && nmask == 0, "R10 operand at 0xFF err", {err, 8'(nmask)}, 9'h100);
  endtask

  task automatic t_busy_go();
    int t = 0;
    mem[8'h00] = 8'h13; mem[8'h01] = 8'h40; mem[8'h02] = 8'h10; mem[8'h03] = 8'h00;
    mem[8'h60] = 8'h11; mem[8'h61] = 8'h00;
    clear_logs();
    @(negedge clk); go = 1; go_addr = 8'h00;
    @(negedge clk); go = 0;
    repeat (20) @(negedge clk);
    go = 1; go_addr = 8'h60;
    @(negedge clk); go = 0;
    while (t < 400) begin @(negedge clk); t++; end
    check(ndone == 1, "R2 single done with go while busy", ndone, 1);
    check(nlog == 1 && log_q[0] == 1, "R2 go while busy ignored", nlog, 1);
    check(!err, "R11 err clear after go", err, 0);
  endtask

  initial begin
    for (int k = 0; k < 256; k++) mem[k] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_acc_order();
    t_enable();
    t_timer();
    t_get();
    t_info();
    t_bounds();
    t_badop();
    t_edge();
    t_busy_go();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act=%0d exp=%0d", 150000, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule